// File: doc/BRIEF.md
# Four-Channel PCM Highway Slot Transceiver

This block connects four voice channels to one shared serial PCM highway. A single bit clock times both serial lines. A single frame-sync input gives the common time base for all channels. The block measures how many bit clocks lie between successive frame-sync rising edges and works out the frame size from that count. It then places an internal frame start 0 to 7 clocks after the sync edge and counts bit positions from that start.

Each channel has its own transmit slot number and receive slot number. In its transmit slot a channel drives its sample onto the serial output, most significant bit first, and asserts the output enable. In its receive slot the channel shifts the incoming bits into a register and hands the completed sample to its datapath with a one-clock strobe. One shared flag selects linear operation. In linear mode each sample is 16 bits wide and fills the programmed slot and the slot after it.

Top module: `pcm_slot_xcvr`

## Requirements
- R1: While reset is asserted and right after it, `lock` is 0, `slot_count` is 0, `tx_oe` is 0 and every `rx_valid` bit is 0.
- R2: When the previous period between frame-sync rising edges is 192 or 193 clocks, `slot_count` is 24. It is 32 for 256 clocks, 64 for 512 clocks and 128 for 1024 clocks. `lock` rises only in the clock after a sampled frame-sync rising edge, and the second such edge after reset is the earliest one that can raise it.
- R3: When the measured period has any other length, `slot_count` is 0 and `lock` is 0. While `lock` is 0, `tx_oe` stays low and no `rx_valid` strobe appears.
- R4: Frame sync is sampled on the rising bit-clock edge, and only its 0-to-1 transition marks a frame. A pulse lasting one clock and a pulse lasting several clocks produce the same timing.
- R5: Let E be the rising edge that first samples frame sync high. The internal frame start is edge E + `fs_delay` (0 to 7). Bit position 0 of slot 0 is the clock period that follows that edge.
- R6: Slot n covers bit positions 8n to 8n+7. In 8-bit mode a channel drives its sample bits [7:0] MSB first on `tx_line` during its transmit slot. `tx_oe` is high in exactly those periods. The line changes on the rising edge.
- R7: With `lin_mode` = 1, the transmit and receive samples are 16 bits, MSB first, and span slots n and n+1, where n is the programmed slot number.
- R8: A channel's transmit sample is taken from `tx_sample` at the rising edge that begins the first bit of its first slot. Later changes to `tx_sample` do not alter the sample already being sent.
- R9: `rx_line` is sampled on the falling bit-clock edge. The completed sample appears on `rx_sample` with a one-clock `rx_valid` pulse in the period right after its last bit. In 8-bit mode the sample is zero-extended, with the received byte in bits [7:0].
- R10: A channel whose last used slot (n, or n+1 in linear mode) is not below `slot_count` neither drives the line nor reports received samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock for both serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs | input | 1 | Frame sync, short or long |
| rx_line | input | 1 | Serial receive data |
| fs_delay | input | 3 | Frame-start delay in clocks after the sync edge |
| lin_mode | input | 1 | 1 selects 16-bit samples over two slots |
| tx_slot_cfg | input | NCH*7 | Transmit slot number per channel, channel c in bits [7c+6:7c] |
| rx_slot_cfg | input | NCH*7 | Receive slot number per channel, same packing |
| tx_sample | input | NCH*16 | Transmit samples, channel c in bits [16c+15:16c] |
| tx_line | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit output enable (low means high impedance) |
| rx_sample | output | NCH*16 | Received samples, same packing as tx_sample |
| rx_valid | output | NCH | One-clock strobe per channel for a new received sample |
| lock | output | 1 | A supported frame size is detected |
| slot_count | output | 8 | Detected slots per frame, 0 when unknown |

## Verification
The hardest case is a sample whose slot lies at the very edge of a frame. Two examples are the final slot of a 193-clock frame followed by its single extra bit, and a linear sample whose second half would run past the last slot. These must be reached while the frame start is also shifted by several clocks. The stimulus runs separate frame lengths, delays and sync pulse widths, and places channels on the first slot, the last slot and slots beyond the frame. The bench also loads the next frame's transmit sample in the middle of a slot, so a late capture of `tx_sample` shows up on the line.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
   localparam int SLOT_BITS = 8;
   localparam int SAMPLE_W  = 2 * SLOT_BITS;
   localparam int MAX_SLOTS = 128;
   localparam int SLOT_W    = $clog2(MAX_SLOTS);
   localparam int POS_W     = $clog2(MAX_SLOTS * SLOT_BITS) + 1;
   localparam int CUR_W     = POS_W - $clog2(SLOT_BITS);
   localparam int CNT_W     = POS_W;
   localparam int NSL_W     = SLOT_W + 1;

   // Map a measured frame period (bit clocks) to a slot count; 0 = unsupported.
   function automatic logic [NSL_W-1:0] slots_for_len(input logic [CNT_W-1:0] len);
      logic [NSL_W-1:0] r;
      case (len)
         CNT_W'(192), CNT_W'(193): r = NSL_W'(24);
         CNT_W'(256):              r = NSL_W'(32);
         CNT_W'(512):              r = NSL_W'(64);
         CNT_W'(1024):             r = NSL_W'(128);
         default:                  r = '0;
      endcase
      return r;
   endfunction

   // Last slot a channel occupies, widened so slot+1 cannot wrap.
   function automatic logic [CUR_W-1:0] last_slot(input logic [SLOT_W-1:0] slot,
                                                  input logic lin);
      return CUR_W'(slot) + CUR_W'(lin);
   endfunction

   // True when the current slot index belongs to this channel's sample.
   function automatic logic slot_hit(input logic [CUR_W-1:0] cur,
                                     input logic [SLOT_W-1:0] slot,
                                     input logic lin,
                                     input logic [NSL_W-1:0] nslots);
      logic fits;
      fits = last_slot(slot, lin) < CUR_W'(nslots);
      return fits && ((cur == CUR_W'(slot)) || (lin && cur == CUR_W'(slot) + CUR_W'(1)));
   endfunction
endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer
   import pcm_slot_pkg::*;
#(
   parameter int SHIFT_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fs,
   input  logic [SHIFT_W-1:0] shift,
   output logic [POS_W-1:0]   pos_nxt,
   output logic [POS_W-1:0]   pos_cur,
   output logic               lock,
   output logic [NSL_W-1:0]   nslots
);
   localparam int NTAP = 2 ** SHIFT_W;
   localparam logic [POS_W-1:0] POS_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic              fs_q;
   logic              fs_edge;
   logic [NTAP-1:0]   taps;
   logic              fstart;
   logic [CNT_W-1:0]  period_cnt;
   logic              seen_edge;
   logic [NSL_W-1:0]  nslots_r;
   logic [POS_W-1:0]  pos_r;

   assign fs_edge = fs & ~fs_q;
   assign taps[0] = fs_edge;

   // Delay line: tap k holds the sync edge seen k clocks ago.
   for (genvar k = 1; k < NTAP; k++) begin : g_tap
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) taps[k] <= 1'b0;
         else        taps[k] <= taps[k-1];
      end
   end

   assign fstart = taps[shift];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q       <= 1'b0;
         period_cnt <= '0;
         seen_edge  <= 1'b0;
         nslots_r   <= '0;
      end else begin
         fs_q <= fs;
         if (fs_edge) begin
            period_cnt <= '0;
            seen_edge  <= 1'b1;
            if (seen_edge) nslots_r <= slots_for_len(period_cnt + CNT_W'(1));
         end else if (period_cnt != CNT_MAX) begin
            period_cnt <= period_cnt + CNT_W'(1);
         end
      end
   end

   always_comb begin
      if (fstart)                pos_nxt = '0;
      else if (pos_r == POS_MAX) pos_nxt = pos_r;
      else                       pos_nxt = pos_r + POS_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos_r <= POS_MAX;
      else        pos_r <= pos_nxt;
   end

   assign pos_cur = pos_r;
   assign nslots  = nslots_r;
   assign lock    = (nslots_r != '0);

   assert_lock_on_fs_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock) |-> ($past(fs) && !$past(fs, 2)));

   assert_slot_count_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (nslots == 8'd0 || nslots == 8'd24 || nslots == 8'd32 ||
       nslots == 8'd64 || nslots == 8'd128));
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
   import pcm_slot_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [POS_W-1:0]    pos_nxt,
   input  logic                lock,
   input  logic                lin,
   input  logic [NSL_W-1:0]    nslots,
   input  logic [SLOT_W-1:0]   slot,
   input  logic [SAMPLE_W-1:0] sample,
   output logic                bit_out,
   output logic                oe
);
   localparam int BIT_LSB = $clog2(SLOT_BITS);

   logic [CUR_W-1:0]    cur;
   logic                hit;
   logic                first;
   logic [SAMPLE_W-1:0] aligned;
   logic [SAMPLE_W-1:0] sh;

   assign cur     = pos_nxt[POS_W-1:BIT_LSB];
   assign hit     = slot_hit(cur, slot, lin, nslots);
   assign first   = hit && (cur == CUR_W'(slot)) && (pos_nxt[BIT_LSB-1:0] == '0);
   assign aligned = lin ? sample : {sample[SLOT_BITS-1:0], {SLOT_BITS{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe      <= 1'b0;
         bit_out <= 1'b0;
         sh      <= '0;
      end else begin
         oe <= lock & hit;
         if (first) begin
            bit_out <= aligned[SAMPLE_W-1];
            sh      <= {aligned[SAMPLE_W-2:0], 1'b0};
         end else if (hit) begin
            bit_out <= sh[SAMPLE_W-1];
            sh      <= {sh[SAMPLE_W-2:0], 1'b0};
         end
      end
   end

   assert_oe_needs_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> $past(lock));
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
   import pcm_slot_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [POS_W-1:0]    pos_cur,
   input  logic                rx_bit,
   input  logic                lock,
   input  logic                lin,
   input  logic [NSL_W-1:0]    nslots,
   input  logic [SLOT_W-1:0]   slot,
   output logic [SAMPLE_W-1:0] data,
   output logic                valid
);
   localparam int BIT_LSB = $clog2(SLOT_BITS);

   logic [CUR_W-1:0]    cur;
   logic                hit;
   logic                last;
   logic [SAMPLE_W-2:0] sh;

   assign cur  = pos_cur[POS_W-1:BIT_LSB];
   assign hit  = slot_hit(cur, slot, lin, nslots);
   assign last = hit && (cur == last_slot(slot, lin)) && (pos_cur[BIT_LSB-1:0] == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         data  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (lock && hit) sh <= {sh[SAMPLE_W-3:0], rx_bit};
         if (lock && last) begin
            valid <= 1'b1;
            data  <= lin ? {sh, rx_bit}
                         : {{SLOT_BITS{1'b0}}, sh[SLOT_BITS-2:0], rx_bit};
         end
      end
   end

   assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

   assert_valid_needs_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> $past(lock));
endmodule

// File: rtl/pcm_slot_xcvr.sv
module pcm_slot_xcvr
   import pcm_slot_pkg::*;
#(
   parameter int NCH     = 4,
   parameter int SHIFT_W = 3
) (
   input  logic                    bclk,
   input  logic                    rst_n,
   input  logic                    fs,
   input  logic                    rx_line,
   input  logic [SHIFT_W-1:0]      fs_delay,
   input  logic                    lin_mode,
   input  logic [NCH*SLOT_W-1:0]   tx_slot_cfg,
   input  logic [NCH*SLOT_W-1:0]   rx_slot_cfg,
   input  logic [NCH*SAMPLE_W-1:0] tx_sample,
   output logic                    tx_line,
   output logic                    tx_oe,
   output logic [NCH*SAMPLE_W-1:0] rx_sample,
   output logic [NCH-1:0]          rx_valid,
   output logic                    lock,
   output logic [NSL_W-1:0]        slot_count
);
   if (NCH < 1) begin : g_bad_nch
      $error("pcm_slot_xcvr: NCH must be at least 1");
   end
   if (SHIFT_W < 1 || SHIFT_W > 4) begin : g_bad_shift
      $error("pcm_slot_xcvr: SHIFT_W must be 1..4");
   end

   logic [POS_W-1:0] pos_nxt;
   logic [POS_W-1:0] pos_cur;
   logic             rx_fall;
   logic [NCH-1:0]   lane_bit;
   logic [NCH-1:0]   lane_oe;

   pcm_frame_timer #(.SHIFT_W(SHIFT_W)) u_timer (
      .clk     (bclk),
      .rst_n   (rst_n),
      .fs      (fs),
      .shift   (fs_delay),
      .pos_nxt (pos_nxt),
      .pos_cur (pos_cur),
      .lock    (lock),
      .nslots  (slot_count)
   );

   // Receive data is taken mid-bit on the falling edge.
   always_ff @(negedge bclk or negedge rst_n) begin
      if (!rst_n) rx_fall <= 1'b0;
      else        rx_fall <= rx_line;
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      pcm_tx_lane u_tx (
         .clk     (bclk),
         .rst_n   (rst_n),
         .pos_nxt (pos_nxt),
         .lock    (lock),
         .lin     (lin_mode),
         .nslots  (slot_count),
         .slot    (tx_slot_cfg[c*SLOT_W +: SLOT_W]),
         .sample  (tx_sample[c*SAMPLE_W +: SAMPLE_W]),
         .bit_out (lane_bit[c]),
         .oe      (lane_oe[c])
      );
      pcm_rx_lane u_rx (
         .clk     (bclk),
         .rst_n   (rst_n),
         .pos_cur (pos_cur),
         .rx_bit  (rx_fall),
         .lock    (lock),
         .lin     (lin_mode),
         .nslots  (slot_count),
         .slot    (rx_slot_cfg[c*SLOT_W +: SLOT_W]),
         .data    (rx_sample[c*SAMPLE_W +: SAMPLE_W]),
         .valid   (rx_valid[c])
      );
   end

   assign tx_line = |(lane_bit & lane_oe);
   assign tx_oe   = |lane_oe;

   assert_line_quiet_when_off_R6: assert property (@(posedge bclk) disable iff (!rst_n)
      !tx_oe |-> !tx_line);
endmodule

// File: tb/pcm_slot_xcvr_bench.sv
module pcm_slot_xcvr_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NCH = 4;
   localparam int NF  = 2;

   logic              bclk = 1'b0;
   logic              rst_n = 1'b0;
   logic              fs = 1'b0;
   logic              rx_line = 1'b0;
   logic [2:0]        fs_delay = '0;
   logic              lin_mode = 1'b0;
   logic [NCH*7-1:0]  tx_slot_cfg = '0;
   logic [NCH*7-1:0]  rx_slot_cfg = '0;
   logic [NCH*16-1:0] tx_sample = '0;
   logic              tx_line;
   logic              tx_oe;
   logic [NCH*16-1:0] rx_sample;
   logic [NCH-1:0]    rx_valid;
   logic              lock;
   logic [7:0]        slot_count;

   int n_chk = 0;
   int n_fail = 0;
   bit armed = 0;
   int q[$];
   int txs[NCH];
   int rxs[NCH];

   pcm_slot_xcvr u_pcm_slot_xcvr (
      .bclk(bclk), .rst_n(rst_n), .fs(fs), .rx_line(rx_line),
      .fs_delay(fs_delay), .lin_mode(lin_mode),
      .tx_slot_cfg(tx_slot_cfg), .rx_slot_cfg(rx_slot_cfg), .tx_sample(tx_sample),
      .tx_line(tx_line), .tx_oe(tx_oe), .rx_sample(rx_sample), .rx_valid(rx_valid),
      .lock(lock), .slot_count(slot_count)
   );

   always #(CLK_PERIOD/2) bclk = ~bclk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] txv(input int f, input int ch);
      return 16'(f * 16'h3b1 + ch * 16'h1357 + 16'ha5c3);
   endfunction
   function automatic logic [15:0] rxv(input int f, input int ch);
      return 16'((f * 16'h2c9) ^ (ch * 16'h0f0f + 16'h5a17));
   endfunction

   // Scoreboard monitor: every strobe must match the oldest expected item.
   initial forever begin
      @(negedge bclk); #1;
      if (armed) begin
         for (int c = 0; c < NCH; c++) begin
            if (rx_valid[c]) begin
               if (q.size() == 0) chk(0, "R9 unexpected strobe", c, -1);
               else begin
                  int item;
                  item = q.pop_front();
                  chk((item >> 16) == c, "R9 channel order", c, item >> 16);
                  chk(rx_sample[c*16 +: 16] == item[15:0], "R9 received sample",
                      rx_sample[c*16 +: 16], item[15:0]);
               end
            end
         end
      end
   end

   task automatic run_scn(input int L, input int s, input bit lng, input bit lin,
                          input int exp_slots, input string tag);
      int e, f, p, first, len;
      bit done, exp_oe, exp_bit, fits, rb;
      logic [15:0] v;
      rst_n = 0; fs = 0; rx_line = 0;
      fs_delay = 3'(s); lin_mode = lin;
      len = lin ? 16 : 8;
      for (int c = 0; c < NCH; c++) begin
         tx_slot_cfg[c*7 +: 7] = 7'(txs[c]);
         rx_slot_cfg[c*7 +: 7] = 7'(rxs[c]);
         tx_sample[c*16 +: 16] = txv(0, c);
      end
      repeat (3) @(posedge bclk);
      @(negedge bclk); rst_n = 1;
      e = -1; done = 0;
      while (!done) begin
         @(posedge bclk); e++; #1;
         // R4: only the rising transition of fs counts, short or long
         fs = lng ? (((e + 1) % L) < 3) : (((e + 1) % L) == 0);
         if (e >= s) begin
            f = (e - s) / L;
            p = (e - s) % L;  // R5: position relative to the delayed frame start
            rb = 0;
            for (int c = 0; c < NCH; c++) begin
               first = rxs[c] * 8;
               fits = (rxs[c] + (lin ? 1 : 0)) < exp_slots;
               v = lin ? rxv(f, c) : {8'h00, rxv(f, c)[7:0]};
               if (fits && p >= first && p < first + len) begin
                  rb = v[len - 1 - (p - first)];
                  if (p == first + len - 1 && f >= 3 && f < 3 + NF)
                     q.push_back((c << 16) | int'(v));
               end
               // R8: next frame's value appears mid-slot; the latched one must go out
               if (p == L - 1 || p == txs[c] * 8 + 2)
                  tx_sample[c*16 +: 16] = txv(f + 1, c);
            end
            rx_line = rb;
            if (f == 3 && p == 1) begin
               armed = 1;
               chk(lock == (exp_slots != 0), "R2/R3 lock", lock, exp_slots != 0);
               chk(slot_count == exp_slots, "R2 R3 slot_count", slot_count, exp_slots);
            end
            if (f == 3 + NF && p == 2) done = 1;
            #(CLK_PERIOD/2);
            if (f >= 3 && f < 3 + NF) begin
               exp_oe = 0; exp_bit = 0;
               for (int c = 0; c < NCH; c++) begin
                  first = txs[c] * 8;
                  fits = (txs[c] + (lin ? 1 : 0)) < exp_slots;
                  v = lin ? txv(f, c) : {txv(f, c)[7:0], 8'h00};
                  if (fits && p >= first && p < first + len) begin
                     exp_oe = 1;
                     exp_bit = v[15 - (p - first)];
                  end
               end
               chk(tx_oe == exp_oe, {tag, " tx_oe"}, tx_oe, exp_oe);
               chk(tx_line == exp_bit, {tag, " tx_line"}, tx_line, exp_bit);
            end
         end
      end
      armed = 0;
      chk(q.size() == 0, "R9 missing strobes", q.size(), 0);
      q.delete();
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(posedge bclk);
      @(negedge bclk); #1;
      // R1: reset state
      chk(lock == 0, "R1 lock", lock, 0);
      chk(slot_count == 0, "R1 slot_count", slot_count, 0);
      chk(tx_oe == 0, "R1 tx_oe", tx_oe, 0);
      chk(rx_valid == 0, "R1 rx_valid", rx_valid, 0);

      txs = '{0, 5, 31, 12};   rxs = '{3, 0, 31, 17};
      run_scn(256, 0, 0, 0, 32, "R6");
      txs = '{1, 7, 30, 20};   rxs = '{2, 9, 30, 24};
      run_scn(256, 5, 1, 1, 32, "R7");
      // R10: slots 40 and 50 lie beyond a 24-slot frame; 193rd bit is idle
      txs = '{23, 0, 40, 11};  rxs = '{0, 23, 50, 6};
      run_scn(193, 7, 0, 0, 24, "R10");
      // R5 with R10: linear sample on slot 127 cannot fit
      txs = '{126, 0, 127, 60}; rxs = '{127, 64, 126, 1};
      run_scn(1024, 3, 1, 1, 128, "R5");
      txs = '{63, 1, 2, 3};    rxs = '{4, 5, 6, 63};
      run_scn(512, 2, 0, 0, 64, "R4");
      txs = '{22, 4, 8, 12};   rxs = '{22, 3, 10, 0};
      run_scn(192, 1, 0, 1, 24, "R2");
      // R3: unsupported period
      txs = '{0, 1, 2, 3};     rxs = '{0, 1, 2, 3};
      run_scn(300, 0, 0, 0, 0, "R3");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule